// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block sequences the chip-select lines of an SPI master and guards it against a second master on the bus. Software writes a transmit word together with a peripheral-select code into a single holding register. The sequencer moves the word into the shift stage, drives the matching active-low chip select, and enforces two programmable spacings. The first is a quiet interval after every transfer. The second is a separate all-lines-high interval whenever chip select is released and then asserted again. The serial shifter is not part of this block. A busy pulse of fixed length stands in for it.

A keep-asserted configuration bit selects between two policies. In the first, chip select is dropped once a transfer ends and nothing is queued. In the second, it stays low through idle time and is dropped only when a word arrives for a different peripheral. The NSS input is synchronised through two flops. A low level on it while the block is enabled sets a sticky fault flag and disables the block. The flag clears when status is read. The block runs again only after an explicit enable pulse. Fault detection can be switched off through a configuration input.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset the block is disabled (`enabled`=0). All chip selects are high, `tx_empty`=1, `fault_flag`=0 and `shift_busy`=0.
- R2: A peripheral-select code with only bit i set drives `cs_n[i]` low and all other lines high. Any other code, including all ones, drives no line low, but the transfer still runs.
- R3: A write is accepted only when `tx_empty`=1 and the block is enabled. `tx_empty` is 0 in the cycle after an accepted write. It returns to 1 on the edge where the word moves to the shifter: `shift_busy` rises and `shift_word` takes the data on that same edge. A write made while `tx_empty`=0 is ignored.
- R4: Each transfer holds `shift_busy` high for exactly XFER_LEN cycles.
- R5: When a word for the same peripheral is queued before the post-transfer delay ends, chip select stays low. `shift_busy` is low for exactly `cfg_dly_bt`+2 cycles between the two transfers.
- R6: When the queued word selects a different peripheral, all lines are high for exactly `cfg_dly_cs`+1 cycles. `shift_busy` is low for `cfg_dly_bt`+`cfg_dly_cs`+3 cycles. One active line never changes directly into another.
- R7: When chip select is released, a new transfer starts `cfg_dly_cs`+2 cycles after the edge that accepts the write.
- R8: With `cfg_keep`=0 and nothing queued, chip select goes high `cfg_dly_bt`+2 cycles after `shift_busy` falls.
- R9: With `cfg_keep`=1, chip select stays low while idle. A later word for the same peripheral starts its transfer one cycle after the edge that accepts the write.
- R10: While enabled with detection on, NSS held low sets `fault_flag` on the third rising edge. On that same edge `enabled` drops, all chip selects go high and any queued word is discarded.
- R11: `fault_flag` stays set until a cycle with `stat_rd`=1, and is 0 after that edge.
- R12: While disabled, writes are ignored. An `en_set` pulse re-enables the block and transfers run again.
- R13: With `cfg_fault_off`=1, NSS low neither sets the fault flag nor disables the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Transmit word |
| wr_pcs | input | NCS | Peripheral-select code for the word |
| en_set | input | 1 | Enable pulse |
| cfg_keep | input | 1 | 1 keeps chip select asserted while idle |
| cfg_fault_off | input | 1 | 1 disables fault detection |
| cfg_dly_bt | input | DLY_W | Delay after each transfer, in cycles |
| cfg_dly_cs | input | DLY_W | Deselect interval, in cycles |
| stat_rd | input | 1 | Status read pulse, clears the fault flag |
| nss_in | input | 1 | NSS input from the bus, active low |
| cs_n | output | NCS | Active-low chip selects |
| shift_busy | output | 1 | Shift stage busy |
| shift_word | output | DW | Word loaded into the shift stage |
| tx_empty | output | 1 | Holding register empty |
| fault_flag | output | 1 | Sticky mode-fault flag |
| enabled | output | 1 | Block enabled |

## Verification
The bound checker watches four things on every cycle. At most one chip select is low. No line hands over directly to another. A disabled block drives every line high. The fault flag is sticky, leaves the block disabled when it rises, and a busy shifter implies an enabled block. Only the bench scenarios can show the exact cycle counts: the post-transfer gap, the deselect interval, the write-to-start latency and the release lag, each under both keep settings. The same holds for the three-edge fault latency through the synchroniser, for read-to-clear, for writes being dropped while full or disabled, and for the re-enable sequence.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_XFER = 2'd2,
    ST_BT   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/spi_cs_nss_sync.sv
module spi_cs_nss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/spi_cs_fault.sv
module spi_cs_fault (
  input  logic clk,
  input  logic rst,
  input  logic en_set,
  input  logic stat_rd,
  input  logic det_off,
  input  logic nss_s,
  output logic enabled,
  output logic fault_flag,
  output logic fault_hit
);
  // Synchronised NSS low while enabled and detection is on
  assign fault_hit = enabled && !det_off && !nss_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled    <= 1'b0;
      fault_flag <= 1'b0;
    end else begin
      if (fault_hit)   enabled <= 1'b0;
      else if (en_set) enabled <= 1'b1;

      if (fault_hit)    fault_flag <= 1'b1;
      else if (stat_rd) fault_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter int NCS = 4
) (
  input  logic [NCS-1:0] code,
  input  logic           act,
  output logic [NCS-1:0] cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign cs_n[i] = !(act && (code == (NCS'(1) << i)));
  end
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer #(
  parameter int DW       = 16,
  parameter int NCS      = 4,
  parameter int DLY_W    = 8,
  parameter int XFER_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [NCS-1:0]   wr_pcs,
  input  logic             en_set,
  input  logic             cfg_keep,
  input  logic             cfg_fault_off,
  input  logic [DLY_W-1:0] cfg_dly_bt,
  input  logic [DLY_W-1:0] cfg_dly_cs,
  input  logic             stat_rd,
  input  logic             nss_in,
  output logic [NCS-1:0]   cs_n,
  output logic             shift_busy,
  output logic [DW-1:0]    shift_word,
  output logic             tx_empty,
  output logic             fault_flag,
  output logic             enabled
);
  import spi_cs_pkg::*;

  localparam int LEN_W = $clog2(XFER_LEN + 1);
  localparam int CNT_W = (DLY_W > LEN_W) ? DLY_W : LEN_W;

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             hold_valid;
  logic [NCS-1:0]   hold_pcs;
  logic [DW-1:0]    hold_data;
  logic [NCS-1:0]   cur_pcs;
  logic             cs_on;
  logic             nss_s;
  logic             fault_hit;

  spi_cs_nss_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(nss_in), .q(nss_s)
  );

  spi_cs_fault u_fault (
    .clk(clk), .rst(rst), .en_set(en_set), .stat_rd(stat_rd),
    .det_off(cfg_fault_off), .nss_s(nss_s),
    .enabled(enabled), .fault_flag(fault_flag), .fault_hit(fault_hit)
  );

  spi_cs_decode #(.NCS(NCS)) u_dec (
    .code(cur_pcs), .act(cs_on), .cs_n(cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      hold_valid <= 1'b0;
      hold_pcs   <= '0;
      hold_data  <= '0;
      cur_pcs    <= '0;
      cs_on      <= 1'b0;
      shift_word <= '0;
    end else if (fault_hit || !enabled) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      hold_valid <= 1'b0;
      cs_on      <= 1'b0;
    end else begin
      if (wr_en && !hold_valid) begin
        hold_valid <= 1'b1;
        hold_pcs   <= wr_pcs;
        hold_data  <= wr_data;
      end
      unique case (state)
        ST_IDLE: begin
          if (hold_valid) begin
            if (cs_on && cur_pcs == hold_pcs) begin
              hold_valid <= 1'b0;
              shift_word <= hold_data;
              cnt        <= CNT_W'(XFER_LEN - 1);
              state      <= ST_XFER;
            end else begin
              cs_on <= 1'b0;
              cnt   <= CNT_W'(cfg_dly_cs);
              state <= ST_GAP;
            end
          end else if (cs_on && !cfg_keep) begin
            cs_on <= 1'b0;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            cs_on      <= 1'b1;
            cur_pcs    <= hold_pcs;
            hold_valid <= 1'b0;
            shift_word <= hold_data;
            cnt        <= CNT_W'(XFER_LEN - 1);
            state      <= ST_XFER;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_XFER: begin
          if (cnt == '0) begin
            cnt   <= CNT_W'(cfg_dly_bt);
            state <= ST_BT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_BT: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign shift_busy = (state == ST_XFER);
  assign tx_empty   = !hold_valid;
endmodule

// File: rtl/spi_cs_sequencer_chk.sv
module spi_cs_sequencer_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCS-1:0] cs_n,
  input logic           shift_busy,
  input logic           stat_rd,
  input logic           fault_flag,
  input logic           enabled
);
  p_one_line_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  p_no_direct_swap_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1 && $past(cs_n) != '1) |-> cs_n == $past(cs_n));

  p_off_all_high_r10: assert property (@(posedge clk) disable iff (rst)
    !enabled |-> cs_n == '1);

  p_fault_disables_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_flag) |-> !enabled);

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (fault_flag && !stat_rd) |=> fault_flag);

  p_busy_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    shift_busy |-> enabled);
endmodule

bind spi_cs_sequencer spi_cs_sequencer_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .shift_busy(shift_busy),
  .stat_rd(stat_rd), .fault_flag(fault_flag), .enabled(enabled)
);

// File: tb/spi_cs_sequencer_bench.sv
module spi_cs_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 8;
  localparam int NV = 6;
  // Table columns: keep, post-transfer delay, deselect delay, codes A/B,
  // expected busy gap and expected all-high gap (0 = no release between)
  localparam int V_KEEP [NV] = '{0, 0, 0, 1, 1, 1};
  localparam int V_BT   [NV] = '{3, 0, 2, 1, 0, 5};
  localparam int V_CS   [NV] = '{2, 0, 4, 3, 1, 0};
  localparam int V_A    [NV] = '{1, 2, 8, 4, 1, 2};
  localparam int V_B    [NV] = '{1, 4, 1, 4, 2, 8};
  localparam int V_GAP  [NV] = '{5, 3, 9, 3, 4, 8};
  localparam int V_CSG  [NV] = '{0, 1, 5, 0, 2, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [3:0] wr_pcs = '0;
  logic en_set = 1'b0;
  logic cfg_keep = 1'b0;
  logic cfg_fault_off = 1'b0;
  logic [7:0] cfg_dly_bt = '0;
  logic [7:0] cfg_dly_cs = '0;
  logic stat_rd = 1'b0;
  logic nss_in = 1'b1;
  logic [3:0] cs_n;
  logic shift_busy;
  logic [15:0] shift_word;
  logic tx_empty;
  logic fault_flag;
  logic enabled;

  spi_cs_sequencer u_spi_cs_sequencer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_pcs(wr_pcs),
    .en_set(en_set), .cfg_keep(cfg_keep), .cfg_fault_off(cfg_fault_off),
    .cfg_dly_bt(cfg_dly_bt), .cfg_dly_cs(cfg_dly_cs), .stat_rd(stat_rd),
    .nss_in(nss_in), .cs_n(cs_n), .shift_busy(shift_busy),
    .shift_word(shift_word), .tx_empty(tx_empty), .fault_flag(fault_flag),
    .enabled(enabled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event monitor, sampled at the falling edge
  int brise [64];
  int bfall [64];
  logic [3:0] cs_at [64];
  logic [15:0] word_at [64];
  int crise [64];
  int cfall [64];
  int nbr = 0, nbf = 0, ncr = 0, ncf = 0;
  logic p_busy = 1'b0;
  logic p_high = 1'b1;
  always @(negedge clk) begin
    if (shift_busy && !p_busy && nbr < 64) begin
      brise[nbr] = cyc; cs_at[nbr] = cs_n; word_at[nbr] = shift_word; nbr++;
    end
    if (!shift_busy && p_busy && nbf < 64) begin
      bfall[nbf] = cyc; nbf++;
    end
    if ((&cs_n) && !p_high && ncr < 64) begin
      crise[ncr] = cyc; ncr++;
    end
    if (!(&cs_n) && p_high && ncf < 64) begin
      cfall[ncf] = cyc; ncf++;
    end
    p_busy = shift_busy;
    p_high = &cs_n;
  end

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] pcs, input logic [15:0] d, output int acc);
    @(negedge clk); wr_en = 1'b1; wr_pcs = pcs; wr_data = d;
    @(negedge clk); wr_en = 1'b0; acc = cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int wa, wb, wc, b0, cr0, cf0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 15);
    chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    chk(fault_flag == 1'b0, "R1 fault", fault_flag, 0);
    chk(enabled == 1'b0, "R1 enabled", enabled, 0);
    chk(shift_busy == 1'b0, "R1 busy", shift_busy, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      cfg_keep = V_KEEP[i][0];
      cfg_dly_bt = 8'(V_BT[i]);
      cfg_dly_cs = 8'(V_CS[i]);
      pulse_en();
      b0 = nbr; cr0 = ncr; cf0 = ncf;
      do_write(4'(V_A[i]), 16'(16'hA000 + i), wa);
      while (!tx_empty) @(negedge clk);
      do_write(4'(V_B[i]), 16'(16'hB000 + i), wb);
      while (nbf < b0 + 2) @(negedge clk);
      chk(brise[b0] - wa == V_CS[i] + 2, "R7 start latency", brise[b0] - wa, V_CS[i] + 2);
      chk(bfall[b0] - brise[b0] == XL, "R4 busy length", bfall[b0] - brise[b0], XL);
      if (V_CSG[i] == 0) begin
        chk(brise[b0+1] - bfall[b0] == V_GAP[i], "R5 same-line gap",
            brise[b0+1] - bfall[b0], V_GAP[i]);
        chk(ncr == cr0, "R5 cs held between", ncr - cr0, 0);
      end else begin
        chk(brise[b0+1] - bfall[b0] == V_GAP[i], "R6 busy gap",
            brise[b0+1] - bfall[b0], V_GAP[i]);
        chk(cfall[cf0+1] - crise[cr0] == V_CSG[i], "R6 all-high interval",
            cfall[cf0+1] - crise[cr0], V_CSG[i]);
      end
      chk(cs_at[b0+1] == ~4'(V_B[i]), "R2 decode", cs_at[b0+1], ~4'(V_B[i]));
      chk(word_at[b0+1] == 16'(16'hB000 + i), "R3 word", word_at[b0+1], 16'hB000 + i);
      repeat (V_BT[i] + 10) @(negedge clk);
      if (V_KEEP[i] == 0) begin
        chk(ncr > cr0 && crise[ncr-1] - bfall[b0+1] == V_BT[i] + 2, "R8 release lag",
            crise[ncr-1] - bfall[b0+1], V_BT[i] + 2);
      end else begin
        chk(cs_n == ~4'(V_B[i]), "R9 cs kept", cs_n, ~4'(V_B[i]));
      end
    end

    // R9: keep mode, same line after idle starts one cycle after accept
    do_write(4'h8, 16'hC0DE, wc);
    while (nbr < 1 || brise[nbr-1] < wc) @(negedge clk);
    chk(brise[nbr-1] - wc == 1, "R9 reuse latency", brise[nbr-1] - wc, 1);
    repeat (20) @(negedge clk);

    // R2/R3: no-line code and write while full
    do_reset();
    cfg_keep = 1'b0; cfg_dly_bt = 8'd0; cfg_dly_cs = 8'd0;
    pulse_en();
    b0 = nbr;
    do_write(4'hF, 16'h1234, wa);
    chk(tx_empty == 1'b0, "R3 tx_empty low", tx_empty, 0);
    do_write(4'h1, 16'h5555, wb);
    repeat (30) @(negedge clk);
    chk(nbr - b0 == 1, "R3 full write ignored", nbr - b0, 1);
    chk(word_at[b0] == 16'h1234, "R3 word moved", word_at[b0], 16'h1234);
    chk(cs_at[b0] == 4'hF, "R2 all-ones selects none", cs_at[b0], 15);

    // R10-R12: fault, sticky flag, re-enable
    cfg_dly_cs = 8'd200;
    do_write(4'h1, 16'h7777, wa);
    nss_in = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(fault_flag == 1'b0, "R10 sync delay", fault_flag, 0);
    @(posedge clk); @(negedge clk);
    chk(fault_flag == 1'b1, "R10 fault set", fault_flag, 1);
    chk(enabled == 1'b0, "R10 disabled", enabled, 0);
    chk(cs_n == 4'hF, "R10 cs high", cs_n, 15);
    chk(tx_empty == 1'b1, "R10 queue dropped", tx_empty, 1);
    nss_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(fault_flag == 1'b1, "R11 sticky", fault_flag, 1);
    do_write(4'h1, 16'h8888, wb);
    chk(tx_empty == 1'b1, "R12 write while disabled", tx_empty, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk(fault_flag == 1'b0, "R11 read clears", fault_flag, 0);
    pulse_en();
    chk(enabled == 1'b1, "R12 re-enabled", enabled, 1);
    cfg_dly_cs = 8'd0;
    b0 = nbr;
    do_write(4'h2, 16'h9999, wc);
    repeat (15) @(negedge clk);
    chk(nbr - b0 == 1, "R12 transfer after re-enable", nbr - b0, 1);

    // R13: detection off
    cfg_fault_off = 1'b1;
    nss_in = 1'b0;
    repeat (10) @(negedge clk);
    chk(fault_flag == 1'b0, "R13 no fault", fault_flag, 0);
    chk(enabled == 1'b1, "R13 stays enabled", enabled, 1);
    nss_in = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule